// File: doc/BRIEF.md
# Two-Level Event Interrupt Controller

This block collects the event flags of a 30-channel digital input unit, plus one input-compare match condition, and turns them into one high-active board interrupt line. Detection of the events is done upstream: the block receives one single-cycle pulse per channel, and one pulse for a compare match. Each pulse latches a sticky flag. Software reads the flags and clears each one by writing 1 to it.

Interrupts are masked at two levels. A per-source enable word selects which flags may raise the board's pending state. A single board-level enable then gates that pending state onto the interrupt pin. The pending state is a separate write-1-to-clear latch. While any enabled flag stays set, the latch is loaded again on every clock. A clear therefore has no effect until all enabled sources have been serviced.

Access goes through a 32-bit register port with a write strobe, a write address and write data, and a separate read address with combinational read data. There are four word registers: the flags at byte offset 0x0, the per-source enables at 0x4, the board enable at 0x8 and the board pending bit at 0xC.

Top module: `evt_irq_ctrl`

## Requirements
- R1: An event pulse on channel i (0..29) sets status bit i at the next clock edge, and a compare-match pulse sets status bit 30. Status bit 31 always reads 0.
- R2: A write to offset 0x0 clears every status flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R3: When an event pulse and a write-1 clear of the same status flag occur in the same cycle, the flag ends up set.
- R4: The enable register at offset 0x4 stores bits 30..0 (bit i enables channel i, bit 30 enables the compare source) and reads them back. Bit 31 reads 0 and ignores writes.
- R5: The board enable is bit 31 of offset 0x8. Bits 30..0 of that register read 0 and ignore writes.
- R6: The pending bit (bit 31 of offset 0xC) is set at the clock edge after any cycle in which a status flag and its enable bit are both 1. A flag whose enable bit is 0 never sets it.
- R7: Writing 1 to bit 31 of offset 0xC clears the pending bit only if no enabled flag is set at that edge. Otherwise the bit stays 1. Bits 30..0 of that register read 0.
- R8: The irq output is registered. It equals the pending bit AND the board enable as they stood one clock earlier.
- R9: After reset all flags, enables and the pending bit read 0, and irq is 0.
- R10: An address whose two low bits are not 00 selects no register: writes to it change nothing, and reads from it return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 30 | Per-channel event pulses from the detection logic |
| cmp_match | input | 1 | Input-compare match pulse |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | 4 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read byte address |
| rd_data | output | 32 | Combinational read data for rd_addr |
| irq | output | 1 | High-active, registered board interrupt |

## Verification
The latencies differ per result. A status flag, an enable bit or a clear is visible on rd_data right after the edge that takes the pulse or write. The pending bit follows one edge after the flag and its enable are both set. irq follows one further edge after the pending bit. The bench drives its stimulus on the falling clock edge and samples one falling edge after each rising edge. Each check sits at its exact edge, and irq is checked both one cycle early (still low) and on time (high), so an extra or a missing register is caught. Every source 0..30 is swept through the same sequence of set, mask, enable, refused clear, write-0, clear and release.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int unsigned REG_DW = 32;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned BOARD_BIT = REG_DW - 1;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_IEN  = 2'd1,
    SEL_GEN  = 2'd2,
    SEL_PEND = 2'd3
  } reg_sel_e;

  // Word-aligned hit test: the low two byte-address bits must be zero
  function automatic logic addr_aligned(input logic [REG_AW-1:0] a);
    return (a[1:0] == 2'b00);
  endfunction

  function automatic reg_sel_e addr_to_sel(input logic [REG_AW-1:0] a);
    return reg_sel_e'(a[3:2]);
  endfunction

  // Next state of a sticky flag: a new set beats a same-cycle clear
  function automatic logic w1c_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // Any flag whose enable is also set
  function automatic logic any_enabled(input logic [REG_DW-1:0] flags,
                                       input logic [REG_DW-1:0] ens);
    return |(flags & ens);
  endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int unsigned N_SRC = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] flag_o
);
  import evt_irq_pkg::*;

  logic [N_SRC-1:0] flag_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= w1c_next(flag_q[i], set_i[i], clr_i[i]);
    end

    // R3: a pulse always leaves the flag set, even against a clear
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_q[i]);

    // R2: a clear without a new pulse drops the flag
    p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_q[i]);

    // R2: with neither set nor clear the flag holds
    p_flag_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_q[i]));
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/evt_irq_pend.sv
module evt_irq_pend #(
  parameter int unsigned N_SRC = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] flags_i,
  input  logic [N_SRC-1:0] ien_i,
  input  logic             gen_en_i,
  input  logic             pend_clr_i,
  output logic             src_active_o,
  output logic             pend_o,
  output logic             irq_o
);
  import evt_irq_pkg::*;

  localparam int unsigned PAD = REG_DW - N_SRC;

  logic src_active;
  logic pend_q;
  logic irq_q;

  assign src_active = any_enabled({{PAD{1'b0}}, flags_i}, {{PAD{1'b0}}, ien_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= w1c_next(pend_q, src_active, pend_clr_i);
      irq_q  <= pend_q & gen_en_i;
    end
  end

  // R6: an enabled flag loads the pending latch on the next edge
  p_pend_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_active |=> pend_o);

  // R7: a clear with no enabled source left drops the pending latch
  p_pend_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr_i && !src_active) |=> !pend_o);

  // R8: irq is the gated pending state one clock later
  p_irq_rises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && gen_en_i) |=> irq_o);
  p_irq_falls_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_o && gen_en_i) |=> !irq_o);

  assign src_active_o = src_active;
  assign pend_o       = pend_q;
  assign irq_o        = irq_q;

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs #(
  parameter int unsigned N_SRC = 31
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [evt_irq_pkg::REG_AW-1:0]    wr_addr,
  input  logic [evt_irq_pkg::REG_DW-1:0]    wr_data,
  input  logic [evt_irq_pkg::REG_AW-1:0]    rd_addr,
  input  logic [N_SRC-1:0]                  flags_i,
  input  logic                              pend_i,
  output logic [N_SRC-1:0]                  stat_clr_o,
  output logic                              pend_clr_o,
  output logic [N_SRC-1:0]                  ien_o,
  output logic                              gen_en_o,
  output logic [evt_irq_pkg::REG_DW-1:0]    rd_data
);
  import evt_irq_pkg::*;

  localparam int unsigned PAD = REG_DW - N_SRC;

  logic             wr_hit;
  reg_sel_e         wr_sel;
  logic             rd_hit;
  reg_sel_e         rd_sel;
  logic [N_SRC-1:0] ien_q;
  logic             gen_q;

  assign wr_hit = wr_en && addr_aligned(wr_addr);
  assign wr_sel = addr_to_sel(wr_addr);
  assign rd_hit = addr_aligned(rd_addr);
  assign rd_sel = addr_to_sel(rd_addr);

  assign stat_clr_o = (wr_hit && wr_sel == SEL_STAT) ? wr_data[N_SRC-1:0] : '0;
  assign pend_clr_o = wr_hit && (wr_sel == SEL_PEND) && wr_data[BOARD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      gen_q <= 1'b0;
    end else if (wr_hit) begin
      if (wr_sel == SEL_IEN) ien_q <= wr_data[N_SRC-1:0];
      if (wr_sel == SEL_GEN) gen_q <= wr_data[BOARD_BIT];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      unique case (rd_sel)
        SEL_STAT: rd_data = {{PAD{1'b0}}, flags_i};
        SEL_IEN:  rd_data = {{PAD{1'b0}}, ien_q};
        SEL_GEN:  rd_data[BOARD_BIT] = gen_q;
        SEL_PEND: rd_data[BOARD_BIT] = pend_i;
        default:  rd_data = '0;
      endcase
    end
  end

  // R5 R7: reserved bits of the board registers read as zero
  p_resv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && (rd_sel == SEL_GEN || rd_sel == SEL_PEND)) |-> (rd_data[BOARD_BIT-1:0] == '0));

  // R10: misaligned reads return zero
  p_misalign_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == '0));

  // R10: misaligned writes leave the enables untouched
  p_misalign_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_aligned(wr_addr)) |=> ($stable(ien_q) && $stable(gen_q)));

  assign ien_o    = ien_q;
  assign gen_en_o = gen_q;

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int unsigned N_IN = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [N_IN-1:0] evt_pulse,
  input  logic        cmp_match,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq
);
  import evt_irq_pkg::*;

  localparam int unsigned N_SRC = N_IN + 1;

  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] stat_clr;
  logic [N_SRC-1:0] ien;
  logic             gen_en;
  logic             pend_clr;
  logic             pend;
  logic             src_active;

  assign set_vec = {cmp_match, evt_pulse};

  evt_flag_bank #(.N_SRC(N_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (stat_clr),
    .flag_o (flags)
  );

  evt_irq_regs #(.N_SRC(N_SRC)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .flags_i    (flags),
    .pend_i     (pend),
    .stat_clr_o (stat_clr),
    .pend_clr_o (pend_clr),
    .ien_o      (ien),
    .gen_en_o   (gen_en),
    .rd_data    (rd_data)
  );

  evt_irq_pend #(.N_SRC(N_SRC)) u_pend (
    .clk          (clk),
    .rst_n        (rst_n),
    .flags_i      (flags),
    .ien_i        (ien),
    .gen_en_i     (gen_en),
    .pend_clr_i   (pend_clr),
    .src_active_o (src_active),
    .pend_o       (pend),
    .irq_o        (irq)
  );

  // R6 R8: with the board enable off the line stays low
  p_gen_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !irq);

  // R1: status bit 31 never reads as set
  p_stat_msb_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 4'h0) |-> !rd_data[31]);

  // R7: a source that is still active keeps the pending bit through a clear
  p_pend_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active && pend_clr) |=> pend);

endmodule

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb;

  localparam logic [3:0] A_STAT = 4'h0;
  localparam logic [3:0] A_IEN  = 4'h4;
  localparam logic [3:0] A_GEN  = 4'h8;
  localparam logic [3:0] A_PEND = 4'hC;
  localparam logic [31:0] BRD   = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [29:0] evt_pulse = '0;
  logic        cmp_match = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cmp_match(cmp_match),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic drive_src(input int i, input logic v);
    if (i < 30) evt_pulse[i] = v;
    else        cmp_match = v;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [31:0] bit_i;
    repeat (3) tick();

    // R9: reset state
    rd(A_STAT, d); check("R9 status", d, 0);
    rd(A_IEN, d);  check("R9 ien", d, 0);
    rd(A_GEN, d);  check("R9 gen", d, 0);
    rd(A_PEND, d); check("R9 pend", d, 0);
    check("R9 irq", {31'b0, irq}, 0);
    rst_n = 1'b1;
    tick();

    // R4 R5: reserved bits
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, d); check("R4 ien readback", d, 32'h7FFF_FFFF);
    wr(A_IEN, 32'h0);
    rd(A_IEN, d); check("R4 ien zero", d, 0);
    wr(A_GEN, 32'h7FFF_FFFF);
    rd(A_GEN, d); check("R5 gen reserved", d, 0);
    wr(A_GEN, 32'hFFFF_FFFF);
    rd(A_GEN, d); check("R5 gen set", d, BRD);

    // Sweep every source 0..30
    for (int i = 0; i < 31; i++) begin
      bit_i = 32'd1 << i;
      drive_src(i, 1'b1);
      tick();
      drive_src(i, 1'b0);
      rd(A_STAT, d); check($sformatf("R1 flag %0d", i), d, bit_i);
      tick();
      rd(A_PEND, d); check($sformatf("R6 masked %0d", i), d, 0);
      check($sformatf("R6 masked irq %0d", i), {31'b0, irq}, 0);
      wr(A_IEN, bit_i);
      rd(A_PEND, d); check($sformatf("R6 before %0d", i), d, 0);
      tick();
      rd(A_PEND, d); check($sformatf("R6 pend %0d", i), d, BRD);
      check($sformatf("R8 irq early %0d", i), {31'b0, irq}, 0);
      tick();
      check($sformatf("R8 irq on %0d", i), {31'b0, irq}, 1);
      wr(A_PEND, BRD);
      rd(A_PEND, d); check($sformatf("R7 refused %0d", i), d, BRD);
      wr(A_STAT, ~bit_i);
      rd(A_STAT, d); check($sformatf("R2 write0 %0d", i), d, bit_i);
      wr(A_STAT, bit_i);
      rd(A_STAT, d); check($sformatf("R2 cleared %0d", i), d, 0);
      wr(A_PEND, BRD);
      rd(A_PEND, d); check($sformatf("R7 cleared %0d", i), d, 0);
      check($sformatf("R8 irq lag %0d", i), {31'b0, irq}, 1);
      tick();
      check($sformatf("R8 irq off %0d", i), {31'b0, irq}, 0);
      wr(A_IEN, 0);

      // R3: pulse and clear of the same flag together
      drive_src(i, 1'b1);
      wr(A_STAT, bit_i);
      drive_src(i, 1'b0);
      rd(A_STAT, d); check($sformatf("R3 set wins %0d", i), d, bit_i);
      wr(A_STAT, bit_i);
      rd(A_STAT, d); check($sformatf("R3 cleanup %0d", i), d, 0);
    end

    // R5 R8: board enable off masks irq but not pending
    wr(A_GEN, 0);
    wr(A_IEN, 32'h4000_0000);
    drive_src(30, 1'b1); tick(); drive_src(30, 1'b0);
    tick(); tick();
    rd(A_PEND, d); check("R5 pend with gen off", d, BRD);
    check("R5 irq gated", {31'b0, irq}, 0);
    wr(A_GEN, BRD);
    check("R8 irq after gen", {31'b0, irq}, 0);
    tick();
    check("R8 irq gen on", {31'b0, irq}, 1);

    // R10: misaligned accesses
    rd(4'h1, d); check("R10 misaligned read", d, 0);
    rd(4'hD, d); check("R10 misaligned pend read", d, 0);
    wr(4'h5, 32'hFFFF_FFFF);
    rd(A_IEN, d); check("R10 misaligned write", d, 32'h4000_0000);
    wr(4'h2, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R10 misaligned clear", d, 32'h4000_0000);

    // Multiple sources: pending held until the last enabled one clears
    wr(A_IEN, 32'h4000_0003);
    evt_pulse[0] = 1'b1; evt_pulse[1] = 1'b1; tick(); evt_pulse = '0;
    wr(A_STAT, 32'h4000_0001);
    wr(A_PEND, BRD);
    rd(A_PEND, d); check("R7 one source left", d, BRD);
    wr(A_STAT, 32'h0000_0002);
    wr(A_PEND, BRD);
    rd(A_PEND, d); check("R7 all serviced", d, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule